// File: doc/BRIEF.md
# SEC-DED Memory Word Protector

This block guards 16-bit memory words with a 6-bit checkword. Writing a word, the host sets write mode, presents the data, and stores the produced checkword next to it. Reading a word back, the host presents the fetched data and checkword, moves into latch mode to capture them and view the error flags, then moves into correct mode. In correct mode the repaired word and the 6-bit syndrome come back on the data and checkword outputs.

Each check bit is an even parity over eight data bits. Every data bit feeds three check bits. Check bits 0 and 1 are stored inverted, so a word stuck at all zeros or all ones cannot pass as clean. A single error in the data or in the checkword is repaired and raises the single flag. Two errors raise both flags, and the data is left as it was. The bidirectional memory buses appear as separate input and output buses, each with an output-enable.

Top module: `edac_sec_ded`

## Requirements
- R1: Data bit i feeds check bit j when bit j of its column is 1. The columns for data bits 0 to 15, in hex, are 0D, 0E, 13, 15, 16, 19, 1A, 1C, 23, 25, 26, 29, 2A, 2C, 31, 32. Each check bit is the XOR of its eight covered data bits. Check bits 0 and 1 (mask 6'b000011) are then inverted.
- R2: Mode 2'b00 is write mode. One rising edge later, chk_o holds the checkword of data_i, chk_oe_o is 1, data_oe_o is 0 and both flags are 0.
- R3: Mode 2'b01 is read mode. One edge later both output-enables are 0 and both flags are 0.
- R4: The latch captures data_i and chk_i only at the edge where mode 2'b11 is entered from another mode. Input values in later cycles of mode 2'b11, and in every other mode, leave the latched word unchanged.
- R5: Mode 2'b11 is latch mode. One edge later both output-enables are 0 and the flags report on the latched word.
- R6: Mode 2'b10 is correct mode. One edge later data_oe_o and chk_oe_o are 1, data_o holds the corrected latched word, and chk_o holds the syndrome. The syndrome is the recomputed checkword XOR the latched checkword. The flags report on the latched word.
- R7: With a consistent latched word, the syndrome is 0, both flags are 0 and data_o equals the latched data.
- R8: With one data bit flipped, the syndrome equals that bit's column. single_err_o is 1, double_err_o is 0, and data_o has that bit inverted back.
- R9: With one checkword bit flipped, the syndrome is that single bit. single_err_o is 1, double_err_o is 0, and data_o equals the latched data.
- R10: Any nonzero syndrome that is neither one bit nor a listed column sets both flags, and data_o is the latched data uncorrected. Two-bit errors produce such syndromes.
- R11: A word of all zeros with checkword 0, and a word of all ones with checkword 6'h3F, each set both flags.
- R12: While rst_ni is low, both output-enables and both flags are 0 at once, and the latch is cleared. A correct-mode read straight after reset, with no capture, therefore reports the zero word with syndrome 6'b000011 and both flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 write, 01 read, 11 latch, 10 correct |
| data_i | input | 16 | Data word from host or memory |
| chk_i | input | 6 | Checkword fetched from memory |
| data_o | output | 16 | Corrected data word |
| data_oe_o | output | 1 | data_o is being driven |
| chk_o | output | 6 | Generated checkword or syndrome |
| chk_oe_o | output | 1 | chk_o is being driven |
| single_err_o | output | 1 | An error was detected |
| double_err_o | output | 1 | The error cannot be corrected |

## Verification
Every result is due exactly one rising edge after the cycle whose mode and inputs produced it. That holds for the write checkword, the output-enables, and the flags and syndrome, which come from the latched word. The driver changes inputs on the falling edge and pushes the expected outputs for that cycle. The monitor pops and compares them 1 ns after the next rising edge, so every comparison falls in the cycle its result is due. Reset is the one exception: it acts at once, and its outputs are checked 1 ns after rst_ni falls.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CHK_W  = 6;
  localparam logic [CHK_W-1:0] INV_MASK = 6'b000011;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_READ  = 2'b01,
    MODE_FIX   = 2'b10,
    MODE_LATCH = 2'b11
  } mode_e;

  function automatic int unsigned popcnt(logic [CHK_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < int'(CHK_W); k++) n += int'(v[k]);
    return n;
  endfunction

  // Four weight-3 codes left out so each row keeps exactly eight ones.
  function automatic logic is_skipped(logic [CHK_W-1:0] v);
    return (v == 6'h07) || (v == 6'h0B) || (v == 6'h34) || (v == 6'h38);
  endfunction

  function automatic logic [CHK_W-1:0] col_of(int unsigned idx);
    int unsigned n;
    logic [CHK_W-1:0] res;
    logic [CHK_W-1:0] cv;
    n   = 0;
    res = '0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      cv = CHK_W'(v);
      if (popcnt(cv) == 3 && !is_skipped(cv)) begin
        if (n == idx) res = cv;
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] row_mask(int unsigned row);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0] c;
    m = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      c    = col_of(i);
      m[i] = c[row];
    end
    return m;
  endfunction
endpackage

// File: rtl/edac_chk_gen.sv
module edac_chk_gen
  import edac_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  for (genvar j = 0; j < CW; j++) begin : g_row
    localparam logic [DW-1:0] MASK = row_mask(j);
    assign chk_o[j] = (^(data_i & MASK)) ^ INV_MASK[j];
  end
endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode
  import edac_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W
) (
  input  logic [CW-1:0] syn_i,
  output logic [DW-1:0] flip_o,
  output logic          single_o,
  output logic          double_o
);
  logic chk_bit_err;

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [CW-1:0] COL = col_of(i);
    assign flip_o[i] = (syn_i == COL);
  end

  assign chk_bit_err = $onehot(syn_i);
  assign single_o    = chk_bit_err || (|flip_o);
  assign double_o    = (syn_i != '0) && !single_o;
endmodule

// File: rtl/edac_word_latch.sv
module edac_word_latch #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] chk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      chk_o  <= '0;
    end else if (cap_i) begin
      data_o <= data_i;
      chk_o  <= chk_i;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(data_o) && $stable(chk_o))); // R4
endmodule

// File: rtl/edac_sec_ded.sv
module edac_sec_ded
  import edac_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [CW-1:0] chk_o,
  output logic          chk_oe_o,
  output logic          single_err_o,
  output logic          double_err_o
);
  mode_e         mode_q;
  logic [CW-1:0] wr_chk, wr_chk_q;
  logic [DW-1:0] lat_data, flip;
  logic [CW-1:0] lat_chk, re_chk, syn;
  logic          capture, dec_single, dec_double, flags_en;

  assign capture = (mode_e'(mode_i) == MODE_LATCH) && (mode_q != MODE_LATCH);

  edac_chk_gen #(.DW(DW), .CW(CW)) i_gen_wr (.data_i(data_i), .chk_o(wr_chk));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_READ;
      wr_chk_q <= '0;
    end else begin
      mode_q <= mode_e'(mode_i);
      if (mode_e'(mode_i) == MODE_WRITE) wr_chk_q <= wr_chk;
    end
  end

  edac_word_latch #(.DW(DW), .CW(CW)) i_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (capture),
    .data_i(data_i),
    .chk_i (chk_i),
    .data_o(lat_data),
    .chk_o (lat_chk)
  );

  edac_chk_gen #(.DW(DW), .CW(CW)) i_gen_rd (.data_i(lat_data), .chk_o(re_chk));

  assign syn = re_chk ^ lat_chk;

  edac_syn_decode #(.DW(DW), .CW(CW)) i_dec (
    .syn_i   (syn),
    .flip_o  (flip),
    .single_o(dec_single),
    .double_o(dec_double)
  );

  assign flags_en     = (mode_q == MODE_LATCH) || (mode_q == MODE_FIX);
  assign single_err_o = flags_en && (dec_single || dec_double);
  assign double_err_o = flags_en && dec_double;
  assign data_o       = dec_double ? lat_data : (lat_data ^ flip);
  assign data_oe_o    = (mode_q == MODE_FIX);
  assign chk_o        = (mode_q == MODE_WRITE) ? wr_chk_q : syn;
  assign chk_oe_o     = (mode_q == MODE_WRITE) || (mode_q == MODE_FIX);

  AST_FLIP_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flip)); // R8
  AST_CHK_ERR_NO_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(syn) == 1) |-> (flip == '0)); // R9
  AST_DOUBLE_NO_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && double_err_o) |-> (data_o == lat_data)); // R10
  AST_DOUBLE_HAS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    double_err_o |-> single_err_o); // R10
  AST_QUIET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |=> (!single_err_o && !double_err_o)); // R3
  AST_WRITE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (chk_oe_o && !data_oe_o)); // R2
  AST_FIX_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |=> (chk_oe_o && data_oe_o)); // R6
  AST_LATCH_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> (!chk_oe_o && !data_oe_o)); // R5
endmodule

// File: tb/test_edac_sec_ded.sv
`timescale 1ns/1ps
module test_edac_sec_ded;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b01;
  logic [15:0] data_i = '0;
  logic [5:0]  chk_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o;
  logic [5:0]  chk_o;
  logic        chk_oe_o;
  logic        single_err_o;
  logic        double_err_o;

  always #2.5 clk_i = ~clk_i;

  edac_sec_ded i_edac_sec_ded (.*);

  typedef struct {
    logic        doe, coe, se, de, cmp_chk, cmp_dat;
    logic [5:0]  chk;
    logic [15:0] dat;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;

  // R1 column list
  localparam logic [5:0] COLS [16] = '{6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19, 6'h1A, 6'h1C,
                                       6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C, 6'h31, 6'h32};

  logic [1:0]  m_mode = 2'b01;
  logic [15:0] m_ld = '0;
  logic [5:0]  m_lc = '0;

  function automatic logic [5:0] gen(logic [15:0] d);
    logic [5:0] c = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 16; i++)
        if (COLS[i][j]) c[j] = c[j] ^ d[i];
    return c ^ 6'b000011;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [15:0] d, input logic [5:0] c,
                       input string tag);
    exp_t e;
    logic [5:0] syn;
    logic [15:0] fl;
    logic se, de;
    @(negedge clk_i);
    mode_i = m; data_i = d; chk_i = c;
    if (m == 2'b11 && m_mode != 2'b11) begin m_ld = d; m_lc = c; end
    m_mode = m;
    syn = gen(m_ld) ^ m_lc;
    fl = '0;
    for (int i = 0; i < 16; i++) if (COLS[i] == syn) fl[i] = 1'b1;
    se = (syn != 0);
    de = (syn != 0) && ($countones(syn) != 1) && (fl == 0);
    e.tag = tag; e.cmp_chk = 1'b0; e.cmp_dat = 1'b0; e.chk = '0; e.dat = '0;
    e.doe = 1'b0; e.coe = 1'b0; e.se = 1'b0; e.de = 1'b0;
    case (m)
      2'b00: begin e.coe = 1'b1; e.cmp_chk = 1'b1; e.chk = gen(d); end
      2'b11: begin e.se = se; e.de = de; end
      2'b10: begin
        e.se = se; e.de = de; e.doe = 1'b1; e.coe = 1'b1;
        e.cmp_chk = 1'b1; e.chk = syn; e.cmp_dat = 1'b1;
        e.dat = de ? m_ld : (m_ld ^ fl);
      end
      default: ;
    endcase
    exp_q.push_back(e);
  endtask

  task automatic read_word(input logic [15:0] d, input logic [5:0] c, input string tag);
    apply(2'b01, d, c, tag);
    apply(2'b11, d, c, tag);
    apply(2'b10, ~d, ~c, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(data_oe_o == e.doe, e.tag, "data_oe", 32'(data_oe_o), 32'(e.doe));
        chk(chk_oe_o == e.coe, e.tag, "chk_oe", 32'(chk_oe_o), 32'(e.coe));
        chk(single_err_o == e.se, e.tag, "single", 32'(single_err_o), 32'(e.se));
        chk(double_err_o == e.de, e.tag, "double", 32'(double_err_o), 32'(e.de));
        if (e.cmp_chk) chk(chk_o == e.chk, e.tag, "chk_o", 32'(chk_o), 32'(e.chk));
        if (e.cmp_dat) chk(data_o == e.dat, e.tag, "data_o", 32'(data_o), 32'(e.dat));
      end
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk_i);
    @(posedge clk_i);
    #2;
  endtask

  task automatic do_reset(input string tag);
    drain();
    @(negedge clk_i);
    mode_i = 2'b01;
    rst_ni = 1'b0;
    #1;
    chk(!data_oe_o && !chk_oe_o, tag, "oe in reset", {data_oe_o, chk_oe_o}, 0);
    chk(!single_err_o && !double_err_o, tag, "flags in reset",
        {single_err_o, double_err_o}, 0);
    m_mode = 2'b01; m_ld = '0; m_lc = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [15:0] w;
    do_reset("R12_start");
    // R2 write checkwords for assorted words, R1 parity table
    apply(2'b00, 16'h0000, 6'h00, "R2_zero");
    apply(2'b00, 16'hFFFF, 6'h00, "R2_ones");
    apply(2'b00, 16'hA5C3, 6'h00, "R1_a5c3");
    apply(2'b00, 16'h0001, 6'h00, "R1_bit0");
    apply(2'b00, 16'h8000, 6'h00, "R1_bit15");
    apply(2'b01, 16'h1234, 6'h15, "R3_read");
    // R7 clean words
    read_word(16'h1234, gen(16'h1234), "R7_1234");
    read_word(16'hBEEF, gen(16'hBEEF), "R7_beef");
    // R8 single data bit
    w = 16'h5A3C;
    for (int i = 0; i < 16; i++) read_word(w ^ (16'h1 << i), gen(w), "R8_data_bit");
    // R9 single check bit
    for (int j = 0; j < 6; j++) read_word(w, gen(w) ^ (6'h1 << j), "R9_chk_bit");
    // R10 double errors
    for (int i = 0; i < 15; i++) read_word(w ^ (16'h3 << i), gen(w), "R10_two_data");
    read_word(w ^ 16'h0100, gen(w) ^ 6'h20, "R10_data_chk");
    read_word(w, gen(w) ^ 6'h09, "R10_two_chk");
    // R11 gross
    read_word(16'h0000, 6'h00, "R11_all_zero");
    read_word(16'hFFFF, 6'h3F, "R11_all_one");
    // R4 hold in latch mode and after
    apply(2'b01, 16'h0F0F, gen(16'h0F0F) ^ 6'h01, "R4_pre");
    apply(2'b11, 16'h0F0F, gen(16'h0F0F) ^ 6'h01, "R4_cap");
    apply(2'b11, 16'h0000, 6'h00, "R4_stay");
    apply(2'b11, 16'hFFFF, 6'h3F, "R4_stay2");
    apply(2'b10, 16'h1111, 6'h11, "R4_fix");
    apply(2'b01, 16'h2222, 6'h22, "R4_read");
    apply(2'b00, 16'h3333, 6'h33, "R4_write");
    apply(2'b10, 16'h4444, 6'h05, "R4_fix_again");
    // R5 latch mode flags on a repairable word
    apply(2'b01, w, gen(w), "R5_pre");
    apply(2'b11, w ^ 16'h0040, gen(w), "R5_latch");
    apply(2'b10, 16'h0, 6'h0, "R6_fix");
    // R12 latch cleared by reset
    read_word(16'hC0DE, gen(16'hC0DE) ^ 6'h02, "R12_pre");
    do_reset("R12_mid");
    apply(2'b10, 16'hFFFF, 6'h3F, "R12_fix_after_reset");
    drain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule